// File: doc/BRIEF.md
# Locked Burst Write Master

This block moves a stream of data words into a memory slave over a shared, arbitrated bus. A frame begins with a one-cycle start pulse that captures a base byte address and a word count. The master then asks the arbiter for the bus. Once granted, it holds the bus locked for as long as the frame needs and writes one word for every acknowledge the slave returns. There is no cap on how many cycles a locked burst may last. A typical use is storing every video frame into the same buffer. For example, a 640 by 480 picture at two bytes per pixel is 153,600 words of 32 bits each.

Words come from a source with a valid/ready handshake. A word leaves the source only on the cycle the slave acknowledges it. A retry from the slave gives up the bus, and the master asks for it again. The burst then resumes at the first word that was not acknowledged. An error acknowledge or a timeout ends the frame at once and sets a sticky error flag.

Top module: `burst_write_master`

## Requirements
- R1: A start pulse seen while idle captures `cfg_base` and `cfg_words`, and `bus_req` is high from the next cycle. A start pulse with a word count of zero is ignored.
- R2: `bus_req` stays high until a cycle in which `bus_gnt` is high. In the cycle after the grant, `bus_req` is low and `bus_sel` is high.
- R3: While selected, `bus_be` is all ones when `src_valid` is high and all zeros otherwise. `src_ready` is high only in a cycle with `bus_sel`, `bus_ack` and `src_valid` high and neither retry, error nor timeout.
- R4: The first word goes to `cfg_base`. Each accepted word advances `bus_addr` by DW/8 bytes.
- R5: `bus_seq` is high while selected except when the word on the bus is the last word of the frame.
- R6: After the last word is accepted, the master is idle on the next cycle. Whenever `bus_sel` is low, `bus_be`, `bus_addr` and `bus_wdata` are zero.
- R7: A retry while selected and with no error or timeout consumes no word. The master requests again from the next cycle. After the new grant it resumes at the same address and with the same word.
- R8: An error or timeout while selected ends the frame on the next cycle and returns the master to idle. `err_flag` is set and stays set until reset. Error and timeout take priority over retry and acknowledge.
- R9: A start pulse while requesting or selected has no effect on the frame in progress.
- R10: With a grant held and the source stalled, the bus stays selected and locked without any cycle limit.
- R11: `bus_req` and `bus_sel` are never high together, and `bus_lock` always equals `bus_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse that begins a frame |
| cfg_base | input | AW | Byte address of the first word |
| cfg_words | input | LW | Number of words in the frame |
| src_valid | input | 1 | Source word available |
| src_data | input | DW | Source word |
| src_ready | output | 1 | Source word consumed this cycle |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_sel | output | 1 | Master owns the bus |
| bus_lock | output | 1 | Bus locked for the burst |
| bus_seq | output | 1 | More words follow the current one |
| bus_be | output | DW/8 | Byte enables |
| bus_addr | output | AW | Byte address of the current word |
| bus_wdata | output | DW | Write data, zero when not selected |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_retry | input | 1 | Slave asks the master to retry |
| bus_err | input | 1 | Error acknowledge |
| bus_timeout | input | 1 | Bus timeout |
| err_flag | output | 1 | Sticky abort indicator |

## Verification
A wrong beat counter shows up first on `bus_seq`, which falls a word too early or too late. One cycle later the bus is released at the wrong point. A wrong address register shows on `bus_addr` in the very cycle it goes wrong. A wrong state shows in the next cycle as a request overlapping select, a lost lock, or data left on an idle bus. A mishandled retry or abort shows as a skipped or repeated word, because the source index and the address stop agreeing.

// File: rtl/bmb_pkg.sv
package bmb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_BURST = 2'd2
  } bm_state_e;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_BEAT  = 2'd1,
    EV_RETRY = 2'd2,
    EV_ABORT = 2'd3
  } bm_event_e;

  // Resolves what the slave said this cycle; abort beats retry beats ack.
  function automatic bm_event_e classify(input logic in_burst,
                                         input logic ack,
                                         input logic retry,
                                         input logic err,
                                         input logic tmo,
                                         input logic valid);
    if (!in_burst)     return EV_NONE;
    if (err || tmo)    return EV_ABORT;
    if (retry)         return EV_RETRY;
    if (ack && valid)  return EV_BEAT;
    return EV_NONE;
  endfunction

endpackage

// File: rtl/bmb_ctl.sv
module bmb_ctl
  import bmb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_go,
  input  logic      bus_gnt,
  input  bm_event_e ev,
  input  logic      last_word,
  output bm_state_e state,
  output logic      err_flag
);

  bm_state_e state_nx;
  logic      err_nx;

  always_comb begin
    state_nx = state;
    err_nx   = err_flag;
    unique case (state)
      ST_IDLE:  if (frame_go) state_nx = ST_REQ;
      ST_REQ:   if (bus_gnt)  state_nx = ST_BURST;
      ST_BURST: begin
        if (ev == EV_ABORT) begin
          state_nx = ST_IDLE;
          err_nx   = 1'b1;
        end else if (ev == EV_RETRY) begin
          state_nx = ST_REQ;
        end else if (ev == EV_BEAT && last_word) begin
          state_nx = ST_IDLE;
        end
      end
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      err_flag <= 1'b0;
    end else begin
      state    <= state_nx;
      err_flag <= err_nx;
    end
  end

endmodule

// File: rtl/bmb_track.sv
module bmb_track #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] addr,
  output logic          more,
  output logic          last
);

  localparam int WBYTES = DW / 8;

  logic [LW-1:0] remain;

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return a + AW'(WBYTES);
  endfunction

  function automatic logic words_after(input logic [LW-1:0] r);
    return r > LW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      remain <= '0;
    end else if (load) begin
      addr   <= base;
      remain <= len;
    end else if (step) begin
      addr   <= next_addr(addr);
      remain <= remain - LW'(1);
    end
  end

  assign more = words_after(remain);
  assign last = (remain == LW'(1));

endmodule

// File: rtl/bmb_drive.sv
module bmb_drive
  import bmb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  bm_state_e       state,
  input  logic [AW-1:0]   addr,
  input  logic            more,
  input  logic            src_valid,
  input  logic [DW-1:0]   src_data,
  output logic            bus_req,
  output logic            bus_sel,
  output logic            bus_lock,
  output logic            bus_seq,
  output logic [DW/8-1:0] bus_be,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata
);

  logic owning;
  logic present;

  assign owning    = (state == ST_BURST);
  assign present   = owning && src_valid;
  assign bus_req   = (state == ST_REQ);
  assign bus_sel   = owning;
  assign bus_lock  = owning;
  assign bus_seq   = owning && more;
  assign bus_be    = present ? '1 : '0;
  assign bus_addr  = owning ? addr : '0;
  assign bus_wdata = present ? src_data : '0;

endmodule

// File: rtl/burst_write_master.sv
module burst_write_master
  import bmb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic [AW-1:0]   cfg_base,
  input  logic [LW-1:0]   cfg_words,
  input  logic            src_valid,
  input  logic [DW-1:0]   src_data,
  output logic            src_ready,
  output logic            bus_req,
  input  logic            bus_gnt,
  output logic            bus_sel,
  output logic            bus_lock,
  output logic            bus_seq,
  output logic [DW/8-1:0] bus_be,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  input  logic            bus_ack,
  input  logic            bus_retry,
  input  logic            bus_err,
  input  logic            bus_timeout,
  output logic            err_flag
);

  bm_state_e state;
  bm_event_e ev;
  logic      frame_go;
  logic      ev_beat;
  logic      ev_retry;
  logic      ev_abort;
  logic      more;
  logic      last;
  logic [AW-1:0] cur_addr;

  assign frame_go = frame_start && (state == ST_IDLE) && (cfg_words != '0);
  assign ev       = classify(state == ST_BURST, bus_ack, bus_retry,
                             bus_err, bus_timeout, src_valid);
  assign ev_beat  = (ev == EV_BEAT);
  assign ev_retry = (ev == EV_RETRY);
  assign ev_abort = (ev == EV_ABORT);
  assign src_ready = ev_beat;

  bmb_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_go (frame_go),
    .bus_gnt  (bus_gnt),
    .ev       (ev),
    .last_word(last),
    .state    (state),
    .err_flag (err_flag)
  );

  bmb_track #(.AW(AW), .DW(DW), .LW(LW)) u_track (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (frame_go),
    .step  (ev_beat),
    .base  (cfg_base),
    .len   (cfg_words),
    .addr  (cur_addr),
    .more  (more),
    .last  (last)
  );

  bmb_drive #(.AW(AW), .DW(DW)) u_drive (
    .state     (state),
    .addr      (cur_addr),
    .more      (more),
    .src_valid (src_valid),
    .src_data  (src_data),
    .bus_req   (bus_req),
    .bus_sel   (bus_sel),
    .bus_lock  (bus_lock),
    .bus_seq   (bus_seq),
    .bus_be    (bus_be),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
  );

endmodule

// File: rtl/bmb_checker.sv
module bmb_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            src_valid,
  input logic            src_ready,
  input logic            bus_req,
  input logic            bus_gnt,
  input logic            bus_sel,
  input logic            bus_lock,
  input logic            bus_seq,
  input logic [DW/8-1:0] bus_be,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            bus_ack,
  input logic            bus_retry,
  input logic            bus_err,
  input logic            bus_timeout,
  input logic            err_flag,
  input logic            ev_beat,
  input logic            ev_retry,
  input logic            ev_abort
);

  localparam int WB = DW / 8;

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);

  assert_grant_owns_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt |=> bus_sel && !bus_req);

  assert_stall_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !src_valid |-> bus_be == '0 && !src_ready);

  assert_ready_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> bus_ack && bus_sel && src_valid);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_beat && bus_seq |=> bus_sel && bus_addr == $past(bus_addr) + AW'(WB));

  assert_last_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_beat && !bus_seq |=> !bus_sel && !bus_req);

  assert_idle_bus_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_be == '0 && bus_addr == '0 && bus_wdata == '0);

  assert_retry_no_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_retry |-> !src_ready);

  assert_retry_rearb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry |=> bus_req && !bus_sel);

  assert_abort_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && (bus_err || bus_timeout) |-> !src_ready);

  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> err_flag && !bus_sel && !bus_req);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_req_sel_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_sel));

  assert_lock_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock == bus_sel);

endmodule

bind burst_write_master bmb_checker #(.AW(AW), .DW(DW)) i_bmb_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_valid   (src_valid),
  .src_ready   (src_ready),
  .bus_req     (bus_req),
  .bus_gnt     (bus_gnt),
  .bus_sel     (bus_sel),
  .bus_lock    (bus_lock),
  .bus_seq     (bus_seq),
  .bus_be      (bus_be),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_ack     (bus_ack),
  .bus_retry   (bus_retry),
  .bus_err     (bus_err),
  .bus_timeout (bus_timeout),
  .err_flag    (err_flag),
  .ev_beat     (ev_beat),
  .ev_retry    (ev_retry),
  .ev_abort    (ev_abort)
);

// File: tb/test_burst_write_master.sv
`timescale 1ns/1ps
module test_burst_write_master;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 20;
  localparam int WB = DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [LW-1:0] cfg_words = '0;
  logic src_valid = 1'b0;
  logic [DW-1:0] src_data;
  logic src_ready, bus_req, bus_sel, bus_lock, bus_seq, err_flag;
  logic bus_gnt = 1'b0, bus_ack = 1'b0, bus_retry = 1'b0;
  logic bus_err = 1'b0, bus_timeout = 1'b0;
  logic [DW/8-1:0] bus_be;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural reference: 0 idle, 1 requesting, 2 owning
  int unsigned m_st = 0;
  int unsigned m_rem = 0;
  logic [AW-1:0] m_addr = '0;
  bit m_err = 0;
  int unsigned word_idx = 0;

  assign src_data = 32'hC0DE0000 ^ word_idx;

  always #4 clk = ~clk;

  burst_write_master #(.AW(AW), .DW(DW), .LW(LW)) i_burst_write_master (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_base(cfg_base),
    .cfg_words(cfg_words), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_sel(bus_sel), .bus_lock(bus_lock), .bus_seq(bus_seq), .bus_be(bus_be),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_retry(bus_retry), .bus_err(bus_err), .bus_timeout(bus_timeout),
    .err_flag(err_flag));

  function automatic bit model_accept();
    return m_st == 2 && !bus_err && !bus_timeout && !bus_retry && bus_ack && src_valid;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_addr = '0; m_err = 0;
    end else begin
      case (m_st)
        0: if (frame_start && cfg_words != 0) begin
             m_st = 1; m_addr = cfg_base; m_rem = cfg_words;
           end
        1: if (bus_gnt) m_st = 2;
        default: begin
          if (bus_err || bus_timeout) begin
            m_st = 0; m_err = 1;
          end else if (bus_retry) begin
            m_st = 1;
          end else if (bus_ack && src_valid) begin
            m_addr = m_addr + WB;
            word_idx++;
            if (m_rem == 1) m_st = 0;
            m_rem--;
          end
        end
      endcase
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (%s) %s: got %h expected %h at %0t", req, tag, what, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit own;
      bit pres;
      own  = (m_st == 2);
      pres = own && src_valid;
      check("R2",  "bus_req",   bus_req,   m_st == 1);
      check("R11", "bus_sel",   bus_sel,   own);
      check("R11", "bus_lock",  bus_lock,  own);
      check("R3",  "bus_be",    bus_be,    pres ? 4'hF : 4'h0);
      check("R3",  "src_ready", src_ready, model_accept());
      check("R4",  "bus_addr",  bus_addr,  own ? m_addr : '0);
      check("R5",  "bus_seq",   bus_seq,   own && m_rem > 1);
      check("R6",  "bus_wdata", bus_wdata, pres ? src_data : '0);
      check("R8",  "err_flag",  err_flag,  m_err);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_bus();
    bus_gnt = 0; bus_ack = 0; bus_retry = 0; bus_err = 0; bus_timeout = 0;
    src_valid = 0; frame_start = 0;
  endtask

  task automatic do_reset();
    clear_bus();
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
  endtask

  task automatic start(input logic [AW-1:0] base, input int len);
    cfg_base = base; cfg_words = LW'(len); frame_start = 1;
    tick();
    frame_start = 0;
  endtask

  task automatic run_frame(input logic [AW-1:0] base, input int len,
                           input int ack_pct, input int valid_pct,
                           input int retry_pct);
    start(base, len);
    for (int k = 0; k < 20000 && m_st != 0; k++) begin
      bus_gnt   = (m_st == 1) && ($urandom_range(99) < 60);
      src_valid = $urandom_range(99) < valid_pct;
      bus_ack   = (m_st == 2) && ($urandom_range(99) < ack_pct);
      bus_retry = (m_st == 2) && ($urandom_range(99) < retry_pct);
      tick();
    end
    clear_bus();
    tick();
  endtask

  initial begin
    int unsigned w0;
    do_reset();
    @(negedge clk);
    tag = "R6";
    check("R6", "reset bus_sel", bus_sel, 0);
    check("R2", "reset bus_req", bus_req, 0);
    check("R8", "reset err_flag", err_flag, 0);
    tick();

    // R1: zero-length frame is ignored
    tag = "R1";
    start(32'h0000_1000, 0);
    @(negedge clk);
    check("R1", "zero count no request", bus_req, 0);
    tick();

    // R1 R2 R4 R5 R6: plain frame, full speed
    start(32'h0000_1000, 4);
    @(negedge clk);
    check("R1", "request after start", bus_req, 1);
    tick();
    repeat (2) tick();
    bus_gnt = 1; tick(); bus_gnt = 0;
    src_valid = 1; bus_ack = 1;
    @(negedge clk);
    check("R4", "first address", bus_addr, 32'h0000_1000);
    while (m_st != 0) tick();
    clear_bus(); tick();

    // R5 single-word frame
    tag = "R5";
    run_frame(32'h0000_0400, 1, 100, 100, 0);

    // R3 source stalls
    tag = "R3";
    run_frame(32'h0001_0000, 12, 90, 40, 0);

    // R7 directed retry
    tag = "R7";
    w0 = word_idx;
    start(32'h0000_3000, 5);
    bus_gnt = 1; tick(); bus_gnt = 0;
    src_valid = 1; bus_ack = 1;
    tick(); tick();
    bus_ack = 0; bus_retry = 1; tick(); bus_retry = 0;
    @(negedge clk);
    check("R7", "request after retry", bus_req, 1);
    check("R7", "released after retry", bus_sel, 0);
    tick();
    bus_gnt = 1; tick(); bus_gnt = 0;
    @(negedge clk);
    check("R7", "resume address", bus_addr, 32'h0000_3008);
    check("R7", "resume word", bus_wdata, 32'hC0DE0000 ^ (w0 + 2));
    tick();
    bus_ack = 1;
    while (m_st != 0) tick();
    clear_bus(); tick();
    run_frame(32'h0002_0000, 40, 70, 85, 8);

    // R9 start during a frame
    tag = "R9";
    start(32'h0000_2000, 6);
    bus_gnt = 1; tick(); bus_gnt = 0;
    src_valid = 1; bus_ack = 1; tick();
    cfg_base = 32'h0000_9000; cfg_words = 3; frame_start = 1; tick(); frame_start = 0;
    @(negedge clk);
    check("R9", "address stays in frame", bus_addr, 32'h0000_2008);
    while (m_st != 0) tick();
    clear_bus(); tick();

    // R10 long stall while locked
    tag = "R10";
    start(32'h0000_5000, 3);
    bus_gnt = 1; tick(); bus_gnt = 0;
    bus_ack = 1; src_valid = 0;
    repeat (3000) tick();
    @(negedge clk);
    check("R10", "still locked", bus_lock, 1);
    check("R10", "still selected", bus_sel, 1);
    tick();
    src_valid = 1;
    while (m_st != 0) tick();
    clear_bus(); tick();

    // longer mixed frame
    tag = "R4";
    run_frame(32'h0010_0000, 300, 70, 80, 2);

    // R8 error abort
    tag = "R8";
    start(32'h0000_6000, 10);
    bus_gnt = 1; tick(); bus_gnt = 0;
    src_valid = 1; bus_ack = 1; repeat (3) tick();
    bus_err = 1; tick(); bus_err = 0; bus_ack = 0;
    @(negedge clk);
    check("R8", "flag after error", err_flag, 1);
    check("R8", "idle after error", bus_sel | bus_req, 0);
    tick();
    run_frame(32'h0000_7000, 5, 100, 100, 0);
    @(negedge clk);
    check("R8", "flag stays set", err_flag, 1);
    tick();

    // R8 timeout together with retry and ack
    do_reset();
    start(32'h0000_8000, 6);
    bus_gnt = 1; tick(); bus_gnt = 0;
    src_valid = 1; bus_ack = 1; tick();
    bus_timeout = 1; bus_retry = 1; tick();
    bus_timeout = 0; bus_retry = 0; bus_ack = 0;
    @(negedge clk);
    check("R8", "timeout wins over retry", bus_req, 0);
    check("R8", "flag after timeout", err_flag, 1);
    tick();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: got hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule